// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt causes for a small 8-bit processor core and presents them as two request lines, one high priority and one low priority. It holds a single 8-bit control/status register. The register has two global gate bits, three enable bits for core-local causes (timer overflow, external pin, pin change) and three sticky flags for those causes. It also takes flag, enable and priority bits from any number of peripheral sources, which are kept outside the block.

A mode input selects how the two global bits work. With the mode low there is no priority. Bit 7 is a master gate and bit 6 is an extra gate for peripheral sources, and every request leaves on the high line. With the mode high, bit 7 gates all high-priority requests and is also a master gate. Bit 6 then gates the low-priority requests. Each peripheral's priority bit picks its line, and the three core causes always go to the high line.

The register port is a plain write strobe with write data and a read-data output that always shows the register. There is no valid/ready handshake on this port, because a write always completes in one cycle and a read has no side effect. Event inputs are single-cycle pulses.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the register reads 0x00 and both request outputs are low.
- R2: A write (wr_en high at a rising edge) loads bits 7..3 from wr_data, and the new value shows on rd_data after that edge.
- R3: A pulse on evt_tmr, evt_ext or evt_pin sets flag bit 2, 1 or 0 at the next edge, whatever the enable and global bits are.
- R4: A flag falls only on a write whose data bit for that flag is 0. If an event and such a write meet in the same cycle, the flag ends up set.
- R5: With prio_mode low, irq_hi = bit7 AND (any core source with flag and enable set, OR (bit6 AND any peripheral with flag and enable set)).
- R6: With prio_mode low, irq_lo stays low.
- R7: With prio_mode high, irq_hi = bit7 AND (any core source with flag and enable set, OR any peripheral with flag, enable and priority bit 1).
- R8: With prio_mode high, irq_lo = bit7 AND bit6 AND any peripheral with flag and enable set and priority bit 0.
- R9: With bit 7 clear, both request outputs are low in either mode.
- R10: A write of 1 to a flag bit sets that flag, so software can raise a cause itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register value |
| evt_tmr | input | 1 | Timer overflow event pulse |
| evt_ext | input | 1 | External pin event pulse |
| evt_pin | input | 1 | Pin change event pulse |
| prio_mode | input | 1 | 1 = two-level priority mode, 0 = compatibility mode |
| periph_flag | input | NUM_PERIPH | Peripheral flags |
| periph_en | input | NUM_PERIPH | Peripheral enables |
| periph_prio | input | NUM_PERIPH | Peripheral priority, 1 = high |
| irq_hi | output | 1 | High-priority request to the core |
| irq_lo | output | 1 | Low-priority request to the core |

## Verification
The bench configures the block with two peripheral sources. It writes every one of the 256 register values, and under each value it drives every combination of mode, peripheral flag, enable and priority. This sweep covers several distinctions. It separates the master gate from the peripheral or low gate. It separates core causes from peripheral ones. In priority mode it shows whether a request goes to the high line or the low line. Directed sequences then pulse each event with every enable cleared, to show that flags latch while masked. They also place a clearing write in the same cycle as an event, to show that the set wins.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W    = 8;
  localparam int CORE_SRC = 3;

  typedef struct packed {
    logic                gate_hi;   // bit 7
    logic                gate_lo;   // bit 6
    logic [CORE_SRC-1:0] core_en;   // bits 5..3 : tmr, ext, pin
    logic [CORE_SRC-1:0] core_fl;   // bits 2..0 : tmr, ext, pin
  } csr_t;
endpackage

// File: rtl/irq_csr.sv
module irq_csr
  import irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [CORE_SRC-1:0] evt,
  output csr_t                csr
);
  csr_t wr_view;
  assign wr_view = csr_t'(wr_data);

  // enable and gate bits: plain software-owned storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr.gate_hi <= 1'b0;
      csr.gate_lo <= 1'b0;
      csr.core_en <= '0;
    end else if (wr_en) begin
      csr.gate_hi <= wr_view.gate_hi;
      csr.gate_lo <= wr_view.gate_lo;
      csr.core_en <= wr_view.core_en;
    end
  end

  // sticky flags: hardware sets, software writes; set beats clear
  for (genvar i = 0; i < CORE_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        csr.core_fl[i] <= 1'b0;
      else if (evt[i])
        csr.core_fl[i] <= 1'b1;
      else if (wr_en)
        csr.core_fl[i] <= wr_view.core_fl[i];
    end
  end
endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate #(
  parameter int N = 4
) (
  input  logic [N-1:0] flag,
  input  logic [N-1:0] en,
  output logic [N-1:0] req
);
  for (genvar i = 0; i < N; i++) begin : g_src
    assign req[i] = flag[i] & en[i];
  end
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int N = 4
) (
  input  logic         prio_mode,
  input  logic         gate_hi,
  input  logic         gate_lo,
  input  logic         core_any,
  input  logic [N-1:0] p_req,
  input  logic [N-1:0] p_prio,
  output logic         irq_hi,
  output logic         irq_lo
);
  logic p_any, p_hi_any, p_lo_any;

  assign p_any    = |p_req;
  assign p_hi_any = |(p_req & p_prio);
  assign p_lo_any = |(p_req & ~p_prio);

  always_comb begin
    if (prio_mode) begin
      irq_hi = gate_hi & (core_any | p_hi_any);
      irq_lo = gate_hi & gate_lo & p_lo_any;
    end else begin
      irq_hi = gate_hi & (core_any | (gate_lo & p_any));
      irq_lo = 1'b0;
    end
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
#(
  parameter int NUM_PERIPH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_data,
  output logic [7:0]            rd_data,
  input  logic                  evt_tmr,
  input  logic                  evt_ext,
  input  logic                  evt_pin,
  input  logic                  prio_mode,
  input  logic [NUM_PERIPH-1:0] periph_flag,
  input  logic [NUM_PERIPH-1:0] periph_en,
  input  logic [NUM_PERIPH-1:0] periph_prio,
  output logic                  irq_hi,
  output logic                  irq_lo
);
  csr_t                csr;
  logic [CORE_SRC-1:0] core_req;
  logic [NUM_PERIPH-1:0] p_req;

  irq_csr u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .evt     ({evt_tmr, evt_ext, evt_pin}),
    .csr     (csr)
  );

  irq_src_gate #(.N(CORE_SRC)) u_core_gate (
    .flag (csr.core_fl),
    .en   (csr.core_en),
    .req  (core_req)
  );

  irq_src_gate #(.N(NUM_PERIPH)) u_periph_gate (
    .flag (periph_flag),
    .en   (periph_en),
    .req  (p_req)
  );

  irq_route #(.N(NUM_PERIPH)) u_route (
    .prio_mode (prio_mode),
    .gate_hi   (csr.gate_hi),
    .gate_lo   (csr.gate_lo),
    .core_any  (|core_req),
    .p_req     (p_req),
    .p_prio    (periph_prio),
    .irq_hi    (irq_hi),
    .irq_lo    (irq_lo)
  );

  assign rd_data = csr;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       evt_tmr,
  input logic       evt_ext,
  input logic       evt_pin,
  input logic       prio_mode,
  input logic       irq_hi,
  input logic       irq_lo
);
  p_enable_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[7:3] == $past(wr_data[7:3]));

  p_evt_tmr_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tmr |=> rd_data[2]);

  p_evt_ext_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ext |=> rd_data[1]);

  p_evt_pin_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pin |=> rd_data[0]);

  p_flag_fall_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[2]) |-> ($past(wr_en) && !$past(wr_data[2])));

  p_lo_quiet_compat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_mode |-> !irq_lo);

  p_lo_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (rd_data[6] && prio_mode));

  p_master_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[7] |-> !(irq_hi || irq_lo));
endmodule

bind irq_ctrl_top irq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .evt_tmr   (evt_tmr),
  .evt_ext   (evt_ext),
  .evt_pin   (evt_pin),
  .prio_mode (prio_mode),
  .irq_hi    (irq_hi),
  .irq_lo    (irq_lo)
);

// File: tb/irq_ctrl_top_tb.sv
module irq_ctrl_top_tb;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    rd_data;
  logic          evt_tmr = 1'b0, evt_ext = 1'b0, evt_pin = 1'b0;
  logic          prio_mode = 1'b0;
  logic [NP-1:0] periph_flag = '0, periph_en = '0, periph_prio = '0;
  logic          irq_hi, irq_lo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_ctrl_top #(.NUM_PERIPH(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .evt_tmr(evt_tmr), .evt_ext(evt_ext),
    .evt_pin(evt_pin), .prio_mode(prio_mode), .periph_flag(periph_flag),
    .periph_en(periph_en), .periph_prio(periph_prio),
    .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic reg_write(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // expected {irq_hi, irq_lo} computed from R5..R9
  function automatic logic [1:0] expect_irq(input logic [7:0] r, input logic pm,
      input logic [NP-1:0] pf, input logic [NP-1:0] pe, input logic [NP-1:0] pp);
    logic core, hi, lo;
    logic [NP-1:0] pr;
    core = |(r[5:3] & r[2:0]);
    pr   = pf & pe;
    if (!pm) begin
      hi = r[7] & (core | (r[6] & (|pr)));
      lo = 1'b0;
    end else begin
      hi = r[7] & (core | (|(pr & pp)));
      lo = r[7] & r[6] & (|(pr & ~pp));
    end
    return {hi, lo};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reg", rd_data, 8'h00);
    check("R1 irq", {6'd0, irq_hi, irq_lo}, 8'h00);

    // R3: flags latch with all enables and gates clear
    reg_write(8'h00);
    evt_tmr = 1'b1; @(negedge clk); evt_tmr = 1'b0;
    check("R3 tmr flag", rd_data, 8'h04);
    evt_ext = 1'b1; @(negedge clk); evt_ext = 1'b0;
    check("R3 ext flag", rd_data, 8'h06);
    evt_pin = 1'b1; @(negedge clk); evt_pin = 1'b0;
    check("R3 pin flag", rd_data, 8'h07);
    check("R9 masked flags no irq", {6'd0, irq_hi, irq_lo}, 8'h00);

    // R4: flags hold without a write; set wins over clear
    repeat (4) @(negedge clk);
    check("R4 hold", rd_data, 8'h07);
    wr_en = 1'b1; wr_data = 8'h00; evt_tmr = 1'b1;
    @(negedge clk); wr_en = 1'b0; evt_tmr = 1'b0;
    check("R4 set wins", rd_data, 8'h04);
    reg_write(8'h00);
    check("R4 clear by write", rd_data, 8'h00);

    // core cause routed high in priority mode
    reg_write(8'h84);
    evt_tmr = 1'b1; @(negedge clk); evt_tmr = 1'b0;
    reg_write(8'hA4);
    prio_mode = 1'b1; #1;
    check("R7 core to hi", {6'd0, irq_hi, irq_lo}, 8'h02);
    prio_mode = 1'b0;

    // exhaustive sweep: every register value x mode x peripheral pattern
    for (int v = 0; v < 256; v++) begin
      reg_write(v[7:0]);
      check("R2 R10 readback", rd_data, v[7:0]);
      for (int c = 0; c < 2 * (1 << (3 * NP)); c++) begin
        logic [1:0] e;
        prio_mode   = c[3*NP];
        periph_flag = c[NP-1:0];
        periph_en   = c[2*NP-1:NP];
        periph_prio = c[3*NP-1:2*NP];
        #1;
        e = expect_irq(v[7:0], prio_mode, periph_flag, periph_en, periph_prio);
        if (!v[7])
          check("R9 sweep", {6'd0, irq_hi, irq_lo}, {6'd0, e});
        else if (prio_mode)
          check("R7 R8 sweep", {6'd0, irq_hi, irq_lo}, {6'd0, e});
        else
          check("R5 R6 sweep", {6'd0, irq_hi, irq_lo}, {6'd0, e});
      end
    end
    finish_run();
  end
endmodule